// File: doc/BRIEF.md
# Two-Key Write-Locked Configuration Register Bank

This block is a small bank of memory-mapped configuration registers guarded against stray writes. A plain register bus (word address, write strobe, write data, read strobe, read data) reaches every register, but the writable ones only accept data once software has deposited two exact 32-bit secrets into two dedicated key locations. The two secrets may arrive in either order. A single wrong value written to either key location throws away all progress and locks the bank again. Software is expected to relock the bank by writing a wrong key as soon as it has finished its update.

Reads are never blocked. Next to the writable registers the bank carries a fixed identification word and a per-core status word. Each clock, the status word records the local-reset and NMI pin levels into the bit pair of the core chosen by a 3-bit core select. Software can read this word but cannot write it.

Word address map: 0 key A, 1 key B, 2..4 writable configuration words, 5 identification word, 6 core status word, all others unmapped.

Top module: `cfglock_bank`

## Requirements
- R1: After synchronous reset the bank is locked, every configuration word reads 0 and the status word reads 0; a reset in mid-operation restores the same state.
- R2: While locked, writes to configuration words (addresses 2, 3, 4) leave them unchanged, and reads of them still return their content.
- R3: Writing 0x83E70B13 to address 0 and 0x95A4F1E0 to address 1, in either order, unlocks the bank; one correct key alone leaves it locked.
- R4: A write of any other value to address 0 or 1 locks the bank and clears both key flags, so a later single correct key does not unlock it.
- R5: While unlocked, a write to a configuration word stores the full 32-bit value, which reads back unchanged.
- R6: The identification word at address 5 reads ID_VALUE (default 0x4B4C0001) and ignores writes whether locked or unlocked.
- R7: A configuration write in the cycle right after the completing key write is accepted; a configuration write in the cycle right after a wrong key write is refused.
- R8: A read of address 0 or 1 returns the lock state in bit 0 (1 = unlocked) with all other bits 0.
- R9: The status word at address 6 holds local-reset of core n in bit n and NMI of core n in bit 8+n, bits 31:16 read 0, and writes to it have no effect.
- R10: On every clock the bit pair of the core selected by core_sel takes the current local-reset and NMI pin levels, and all other status bits hold.
- R11: Reads of unmapped addresses (7..15) return 0, and read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Read data, combinational from address and state |
| core_sel | input | 3 | Core whose status bit pair is updated this cycle |
| core_lrst_pin | input | 1 | Local-reset level of the selected core |
| core_nmi_pin | input | 1 | NMI level of the selected core |

## Verification
The properties assume a single bus operation per cycle, with address and write data stable across the clock edge at which the write strobe is sampled, and pin levels that are valid at every edge since the status pair is written each cycle. The stimulus drives all inputs at the falling edge and holds them through the next rising edge, and keeps the core pins at zero during the table walk so that the status word only moves in the dedicated status tests.

// File: rtl/cfglock_pkg.sv
package cfglock_pkg;

    localparam int DATA_W = 32;

    // Address positions of the bank; the writable words follow the keys.
    localparam int KEY_A_ADDR = 0;
    localparam int KEY_B_ADDR = 1;
    localparam int CFG_BASE   = 2;
    localparam int NUM_KEYS   = 2;

    localparam logic [DATA_W-1:0] KEY_A_SECRET = 32'h83E7_0B13;
    localparam logic [DATA_W-1:0] KEY_B_SECRET = 32'h95A4_F1E0;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    typedef enum logic [2:0] {
        SLOT_KEY,
        SLOT_CFG,
        SLOT_IDENT,
        SLOT_STAT,
        SLOT_NONE
    } slot_e;

    function automatic logic [DATA_W-1:0] key_secret(input int idx);
        return (idx == 0) ? KEY_A_SECRET : KEY_B_SECRET;
    endfunction

    function automatic int ident_addr(input int num_cfg);
        return CFG_BASE + num_cfg;
    endfunction

    function automatic int stat_addr(input int num_cfg);
        return CFG_BASE + num_cfg + 1;
    endfunction

endpackage

// File: rtl/cfglock_key_fsm.sv
module cfglock_key_fsm
    import cfglock_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] key_wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                unlocked
);

    logic [NUM_KEYS-1:0] flag_q;
    logic [NUM_KEYS-1:0] match;

    generate
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_match
            assign match[k] = key_wr[k] && (wdata == key_secret(k));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else if (|key_wr) begin
            if (|match) begin
                flag_q <= flag_q | match;
            end else begin
                flag_q <= '0;
            end
        end
    end

    assign unlocked = &flag_q;

endmodule

// File: rtl/cfglock_cfg_regs.sv
module cfglock_cfg_regs
    import cfglock_pkg::*;
#(
    parameter int                NUM_CFG   = 3,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CFG-1:0]        cfg_wr,
    input  logic                      unlocked,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_CFG*DATA_W-1:0] cfg_q
);

    generate
        for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[i*DATA_W +: DATA_W] <= RESET_VAL;
                end else if (cfg_wr[i] && unlocked) begin
                    cfg_q[i*DATA_W +: DATA_W] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfglock_status.sv
module cfglock_status
    import cfglock_pkg::*;
#(
    parameter int NCORES = 8,
    localparam int SEL_W = $clog2(NCORES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              lrst_pin,
    input  logic              nmi_pin,
    output logic [DATA_W-1:0] stat
);

    logic [NCORES-1:0] lrst_q;
    logic [NCORES-1:0] nmi_q;

    generate
        for (genvar c = 0; c < NCORES; c++) begin : g_core
            always_ff @(posedge clk) begin
                if (rst) begin
                    lrst_q[c] <= 1'b0;
                    nmi_q[c]  <= 1'b0;
                end else if (sel == SEL_W'(c)) begin
                    lrst_q[c] <= lrst_pin;
                    nmi_q[c]  <= nmi_pin;
                end
            end
        end
    endgenerate

    assign stat = DATA_W'({nmi_q, lrst_q});

endmodule

// File: rtl/cfglock_bank.sv
module cfglock_bank
    import cfglock_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                NUM_CFG  = 3,
    parameter int                NCORES   = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h4B4C_0001
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr_en,
    input  logic [DATA_W-1:0]         bus_wr_data,
    input  logic                      bus_rd_en,
    output logic [DATA_W-1:0]         bus_rd_data,
    input  logic [$clog2(NCORES)-1:0] core_sel,
    input  logic                      core_lrst_pin,
    input  logic                      core_nmi_pin
);

    localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(KEY_A_ADDR);
    localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(KEY_B_ADDR);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(ident_addr(NUM_CFG));
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(stat_addr(NUM_CFG));

    bus_op_t                   op;
    slot_e                     slot;
    logic [NUM_KEYS-1:0]       key_wr;
    logic [NUM_CFG-1:0]        cfg_hit;
    logic [NUM_CFG-1:0]        cfg_wr;
    logic                      unlocked;
    logic [NUM_CFG*DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0]         stat_q;
    logic [DATA_W-1:0]         cfg_rd;

    assign op = '{wr: bus_wr_en, rd: bus_rd_en, wdata: bus_wr_data};

    generate
        for (genvar i = 0; i < NUM_CFG; i++) begin : g_dec
            assign cfg_hit[i] = (bus_addr == ADDR_W'(CFG_BASE + i));
        end
    endgenerate

    always_comb begin
        if (bus_addr == A_KEY_A || bus_addr == A_KEY_B) begin
            slot = SLOT_KEY;
        end else if (|cfg_hit) begin
            slot = SLOT_CFG;
        end else if (bus_addr == A_IDENT) begin
            slot = SLOT_IDENT;
        end else if (bus_addr == A_STAT) begin
            slot = SLOT_STAT;
        end else begin
            slot = SLOT_NONE;
        end
    end

    assign key_wr[0] = op.wr && (bus_addr == A_KEY_A);
    assign key_wr[1] = op.wr && (bus_addr == A_KEY_B);
    assign cfg_wr    = op.wr ? cfg_hit : '0;

    cfglock_key_fsm u_keys (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .wdata    (op.wdata),
        .unlocked (unlocked)
    );

    cfglock_cfg_regs #(
        .NUM_CFG   (NUM_CFG),
        .RESET_VAL ('0)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .unlocked (unlocked),
        .wdata    (op.wdata),
        .cfg_q    (cfg_q)
    );

    cfglock_status #(
        .NCORES (NCORES)
    ) u_stat (
        .clk      (clk),
        .rst      (rst),
        .sel      (core_sel),
        .lrst_pin (core_lrst_pin),
        .nmi_pin  (core_nmi_pin),
        .stat     (stat_q)
    );

    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (cfg_hit[i]) begin
                cfg_rd = cfg_q[i*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        bus_rd_data = '0;
        if (op.rd) begin
            unique case (slot)
                SLOT_KEY:   bus_rd_data = DATA_W'(unlocked);
                SLOT_CFG:   bus_rd_data = cfg_rd;
                SLOT_IDENT: bus_rd_data = ID_VALUE;
                SLOT_STAT:  bus_rd_data = stat_q;
                default:    bus_rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfglock_bank_chk.sv
module cfglock_bank_chk
    import cfglock_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_CFG = 3,
    parameter int NCORES  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_wr_en,
    input logic [DATA_W-1:0]         bus_wr_data,
    input logic                      bus_rd_en,
    input logic [DATA_W-1:0]         bus_rd_data,
    input logic [$clog2(NCORES)-1:0] core_sel,
    input logic                      core_lrst_pin,
    input logic                      core_nmi_pin,
    input logic                      unlocked,
    input logic [NUM_CFG*DATA_W-1:0] cfg_q,
    input logic [DATA_W-1:0]         stat_q
);

    logic key_a_wr;
    logic key_b_wr;
    logic bad_key;

    assign key_a_wr = bus_wr_en && (bus_addr == ADDR_W'(KEY_A_ADDR));
    assign key_b_wr = bus_wr_en && (bus_addr == ADDR_W'(KEY_B_ADDR));
    assign bad_key  = (key_a_wr && bus_wr_data != KEY_A_SECRET) ||
                      (key_b_wr && bus_wr_data != KEY_B_SECRET);

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !unlocked); // R1

    AST_LOCKED_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(cfg_q)); // R2

    AST_UNLOCK_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_a_wr || key_b_wr)); // R3

    AST_BAD_KEY_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        bad_key |=> !unlocked); // R4

    AST_STAT_LRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat_q[$past(core_sel)] == $past(core_lrst_pin)); // R10

    AST_STAT_NMI_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat_q[NCORES + int'($past(core_sel))] == $past(core_nmi_pin)); // R10

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |-> bus_rd_data == '0); // R11

endmodule

bind cfglock_bank cfglock_bank_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_CFG (NUM_CFG),
    .NCORES  (NCORES)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr_en     (bus_wr_en),
    .bus_wr_data   (bus_wr_data),
    .bus_rd_en     (bus_rd_en),
    .bus_rd_data   (bus_rd_data),
    .core_sel      (core_sel),
    .core_lrst_pin (core_lrst_pin),
    .core_nmi_pin  (core_nmi_pin),
    .unlocked      (unlocked),
    .cfg_q         (cfg_q),
    .stat_q        (stat_q)
);

// File: tb/cfglock_bank_tb.sv
module cfglock_bank_tb_top;

    localparam logic [31:0] TB_ID = 32'h4B4C_0001;
    localparam logic [31:0] KA    = 32'h83E7_0B13;
    localparam logic [31:0] KB    = 32'h95A4_F1E0;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd2, 32'h0,         32'h0,         4'd1},  // R1 cfg word clear
        '{1'b0, 4'd0, 32'h0,         32'h0,         4'd1},  // R1 locked after reset
        '{1'b1, 4'd2, 32'hAAAA_5555, 32'h0,         4'd2},  // R2 write while locked
        '{1'b0, 4'd2, 32'h0,         32'h0,         4'd2},  // R2 unchanged
        '{1'b1, 4'd0, KA,            32'h0,         4'd3},  // R3 first key
        '{1'b0, 4'd0, 32'h0,         32'h0,         4'd3},  // R3 one key not enough
        '{1'b1, 4'd1, KB,            32'h0,         4'd3},  // R3 second key
        '{1'b0, 4'd1, 32'h0,         32'h1,         4'd8},  // R8 unlocked in bit 0
        '{1'b1, 4'd3, 32'h1234_5678, 32'h0,         4'd5},  // R5 write accepted
        '{1'b0, 4'd3, 32'h0,         32'h1234_5678, 4'd5},  // R5 readback
        '{1'b1, 4'd5, 32'hFFFF_FFFF, 32'h0,         4'd6},  // R6 write to ident
        '{1'b0, 4'd5, 32'h0,         TB_ID,         4'd6},  // R6 ident intact
        '{1'b1, 4'd1, 32'h0,         32'h0,         4'd4},  // R4 wrong key relocks
        '{1'b1, 4'd4, 32'hDEAD_BEEF, 32'h0,         4'd4},  // R4 refused
        '{1'b0, 4'd4, 32'h0,         32'h0,         4'd4},  // R4 still clear
        '{1'b0, 4'd0, 32'h0,         32'h0,         4'd4},  // R4 locked
        '{1'b1, 4'd1, KB,            32'h0,         4'd3},  // R3 reversed order
        '{1'b0, 4'd0, 32'h0,         32'h0,         4'd3},  // R3 half way
        '{1'b1, 4'd0, KA,            32'h0,         4'd3},
        '{1'b0, 4'd0, 32'h0,         32'h1,         4'd3},  // R3 unlocked
        '{1'b1, 4'd0, KA ^ 32'h1,    32'h0,         4'd4},  // R4 near-miss key
        '{1'b1, 4'd1, KB,            32'h0,         4'd4},  // R4 progress was cleared
        '{1'b0, 4'd1, 32'h0,         32'h0,         4'd4},
        '{1'b0, 4'd9, 32'h0,         32'h0,         4'd11}, // R11 unmapped
        '{1'b1, 4'd6, 32'hFFFF_FFFF, 32'h0,         4'd9},  // R9 write to status
        '{1'b0, 4'd6, 32'h0,         32'h0,         4'd9}   // R9 status unchanged
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rd_data;
    logic [2:0]  core_sel = '0;
    logic        core_lrst_pin = 1'b0;
    logic        core_nmi_pin = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] got;

    always #4 clk = ~clk;

    cfglock_bank #(.ID_VALUE(TB_ID)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr_en     (bus_wr_en),
        .bus_wr_data   (bus_wr_data),
        .bus_rd_en     (bus_rd_en),
        .bus_rd_data   (bus_rd_data),
        .core_sel      (core_sel),
        .core_lrst_pin (core_lrst_pin),
        .core_nmi_pin  (core_nmi_pin)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample read data before the rising edge.
    task automatic bus_cycle(input logic wr, input logic rd, input logic [3:0] a,
                             input logic [31:0] d);
        @(negedge clk);
        bus_wr_en   = wr;
        bus_rd_en   = rd;
        bus_addr    = a;
        bus_wr_data = d;
        #2 got = bus_rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_cycle(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_chk(input int req, input logic [3:0] a, input logic [31:0] exp);
        bus_cycle(1'b0, 1'b1, a, 32'h0);
        check(req, got, exp);
    endtask

    task automatic pins(input logic [2:0] s, input logic l, input logic n);
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_rd_en = 1'b0;
        core_sel = s;
        core_lrst_pin = l;
        core_nmi_pin = n;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd_chk(1, 4'd6, 32'h0); // R1 status clear after reset

        for (int i = 0; i < NV; i++) begin
            bus_cycle(VECS[i].wr, !VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr) check(int'(VECS[i].req), got, VECS[i].exp);
        end

        // R7: configuration write directly after the completing key write
        wr(4'd0, KA);
        wr(4'd1, KB);
        wr(4'd2, 32'hCAFE_0001);
        rd_chk(7, 4'd2, 32'hCAFE_0001);
        // R7: configuration write directly after a wrong key write
        wr(4'd0, 32'h0);
        wr(4'd2, 32'hCAFE_0002);
        rd_chk(7, 4'd2, 32'hCAFE_0001);

        // R11: read strobe low gives zero even on a mapped word
        bus_cycle(1'b0, 1'b0, 4'd2, 32'h0);
        check(11, got, 32'h0);
        rd_chk(11, 4'd15, 32'h0);

        // R10 / R9: status bit pairs
        pins(3'd3, 1'b1, 1'b0);
        rd_chk(10, 4'd6, 32'h0000_0008);
        pins(3'd5, 1'b1, 1'b1);
        rd_chk(10, 4'd6, 32'h0000_2028);
        pins(3'd3, 1'b0, 1'b1);
        rd_chk(10, 4'd6, 32'h0000_2820);
        pins(3'd7, 1'b0, 1'b0);
        wr(4'd0, KA);
        wr(4'd1, KB);
        wr(4'd6, 32'hFFFF_FFFF); // R9 not writable even when unlocked
        rd_chk(9, 4'd6, 32'h0000_2820);
        wr(4'd5, 32'h0); // R6 ident ignores write while unlocked
        rd_chk(6, 4'd5, TB_ID);

        // R1: reset in mid-operation
        wr(4'd4, 32'h5A5A_5A5A);
        rd_chk(5, 4'd4, 32'h5A5A_5A5A);
        @(negedge clk);
        bus_rd_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk(1, 4'd4, 32'h0);
        rd_chk(1, 4'd0, 32'h0);
        rd_chk(1, 4'd6, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule